// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers every interrupt cause of a small Ethernet MAC into one 8-bit status word and drives a single level interrupt line. It serves a host-side register port. The status word mixes three kinds of bit:

- Sticky bits are set by events and cleared by a write-one acknowledge.
- Live bits mirror the empty flags of the receive queue and the transmit-completion queue, and the allocator's failure flag.
- One summary bit ORs together several MAC status conditions, each with its own enable.

A host reads the status word and programs the mask. It then acknowledges what it has serviced. Acknowledging a transmit completion also removes that entry from the head of the completion queue, through a one-cycle pop output.

The register map is as follows:

| Address | Register | Access |
|---|---|---|
| 0 | Status | read only |
| 1 | Mask | read/write |
| 2 | Acknowledge | write only, reads 0 |
| 3 | Event enables | read/write |
| 4 | Early-receive threshold | read/write |

Any other address reads 0 and ignores writes. Register reads are combinational. Register writes, sticky sets and sticky clears take effect at the next clock edge.

Top module: `nic_irq_hub`

## Requirements
- R1: Status bit 0 (receive) equals the inverse of `rxq_empty` in the same cycle, and status bit 7 always reads 0.
- R2: Status bit 1 (transmit) equals the inverse of `txc_empty`. A write to address 2 with data bit 1 set pulses `txc_pop` in that same cycle, but only if `txc_empty` is low. `txc_pop` is low at all other times.
- R3: Status bit 3 (allocation) equals the inverse of `alloc_failed` in the same cycle.
- R4: Status bit 2 (transmit-empty) sets at the clock edge where `txq_empty` is high. It then holds until an acknowledge write with data bit 2 set, which clears it at that edge.
- R5: Status bit 4 (receive-overrun) sets at the edge after any of `rxo_nomem`, `rxo_toolong` or `rxo_discard` is high. It clears only through an acknowledge write with data bit 4 set.
- R6: Status bit 6 (early-receive) sets at an edge where `rx_active` is high and `rx_bytes` is strictly greater than the threshold register times 8. It clears only through an acknowledge write with data bit 6 set.
- R7: Status bit 5 (event summary) is the OR of three gated conditions. Each condition is an input ANDed with its enable bit at address 3: bit 0 gates `ev_link`, bit 1 gates `ev_ctr_roll` and bit 2 gates `ev_tx_halt`.
- R8: `irq` is high exactly when the status word ANDed with the mask register (address 1) is nonzero. It follows mask and status changes in the same cycle.
- R9: When a sticky bit's set condition and its acknowledge arrive in the same cycle, the bit is set after that edge.
- R10: Acknowledge writes to bits 0, 3, 5 and 7 change no status bit.
- R11: After reset, the sticky bits, the mask and the enables are 0 and the threshold is 0xFF. Address 2 and any address above 4 read 0. Address 3 reads the enables in bits 2:0 with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rxq_empty | input | 1 | Receive queue empty |
| txc_empty | input | 1 | Transmit-completion queue empty |
| txc_pop | output | 1 | Remove the head of the completion queue |
| txq_empty | input | 1 | Transmit queue empty |
| alloc_failed | input | 1 | Allocator reports failure |
| rxo_nomem | input | 1 | Receive failed for lack of memory |
| rxo_toolong | input | 1 | Received frame exceeded 1536 bytes |
| rxo_discard | input | 1 | Reception aborted by a discard command |
| rx_active | input | 1 | A frame is being received |
| rx_bytes | input | CNT_W (11) | Bytes of the current frame stored in memory |
| ev_link | input | 1 | Link-state change flag |
| ev_ctr_roll | input | 1 | Statistics counter rollover flag |
| ev_tx_halt | input | 1 | Transmit halted by a fatal error |
| irq | output | 1 | Interrupt request, level |

## Verification
Live status bits, `irq` and `txc_pop` are combinational, so they are due in the same cycle as the stimulus. The bench therefore compares them one time unit after driving inputs at the falling edge. Sticky bits and register writes land at the next rising edge, so the bench's reference model applies them only when it sees that edge. The model's prediction is then compared at the following falling edge, one cycle after the stimulus. Every compare happens while inputs are steady, half a period away from any active edge.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   localparam int ST_W     = 8;
   localparam int ST_RX    = 0;
   localparam int ST_TX    = 1;
   localparam int ST_TXE   = 2;
   localparam int ST_ALLOC = 3;
   localparam int ST_RXO   = 4;
   localparam int ST_EVT   = 5;
   localparam int ST_ERX   = 6;
   localparam int ST_RSV   = 7;

   localparam int N_STICKY = 3;
   localparam int N_EVT    = 3;

   localparam int A_STAT = 0;
   localparam int A_MASK = 1;
   localparam int A_ACK  = 2;
   localparam int A_EVEN = 3;
   localparam int A_THR  = 4;

   localparam logic [ST_W-1:0] THR_RST = 8'hFF;
endpackage

// File: rtl/nic_irq_sticky.sv
module nic_irq_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("nic_irq_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[i] <= 1'b0;
         else        q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
      end

      // R4: a set bit without an acknowledge stays set
      p_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[i] && !clr_i[i]) |=> q_o[i]);
      // R9: the set condition overrides a simultaneous acknowledge
      p_set_wins_r9 : assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);
      // R4: an acknowledge with no set condition clears the bit
      p_clear_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);
   end
endmodule

// File: rtl/nic_irq_evsum.sv
module nic_irq_evsum #(
   parameter int N = 3
) (
   input  logic [N-1:0] ev_i,
   input  logic [N-1:0] en_i,
   output logic         any_o
);
   logic [N-1:0] gated;

   for (genvar i = 0; i < N; i++) begin : g_src
      assign gated[i] = ev_i[i] & en_i[i];
   end

   assign any_o = |gated;
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
   import nic_irq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ST_W-1:0]   wdata_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [ST_W-1:0]   mask_o,
   output logic [N_EVT-1:0]  en_o,
   output logic [ST_W-1:0]   thr_o,
   output logic [ST_W-1:0]   ack_o,
   output logic [ST_W-1:0]   rdata_o
);
   logic hit_mask, hit_ack, hit_en, hit_thr;

   assign hit_mask = wr_i && (addr_i == ADDR_W'(A_MASK));
   assign hit_ack  = wr_i && (addr_i == ADDR_W'(A_ACK));
   assign hit_en   = wr_i && (addr_i == ADDR_W'(A_EVEN));
   assign hit_thr  = wr_i && (addr_i == ADDR_W'(A_THR));

   assign ack_o = hit_ack ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= '0;
         en_o   <= '0;
         thr_o  <= THR_RST;
      end else begin
         if (hit_mask) mask_o <= wdata_i;
         if (hit_en)   en_o   <= wdata_i[N_EVT-1:0];
         if (hit_thr)  thr_o  <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      if      (addr_i == ADDR_W'(A_STAT)) rdata_o = status_i;
      else if (addr_i == ADDR_W'(A_MASK)) rdata_o = mask_o;
      else if (addr_i == ADDR_W'(A_EVEN)) rdata_o = ST_W'(en_o);
      else if (addr_i == ADDR_W'(A_THR))  rdata_o = thr_o;
   end

   // R11: a write elsewhere leaves the mask untouched
   p_mask_stable_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !hit_mask |=> $stable(mask_o));
endmodule

// File: rtl/nic_irq_hub.sv
module nic_irq_hub
   import nic_irq_pkg::*;
#(
   parameter int ADDR_W        = 3,
   parameter int CNT_W         = 11,
   parameter int THR_SHIFT     = 3,
   parameter bit ERX_INCLUSIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              rxq_empty,
   input  logic              txc_empty,
   output logic              txc_pop,
   input  logic              txq_empty,
   input  logic              alloc_failed,
   input  logic              rxo_nomem,
   input  logic              rxo_toolong,
   input  logic              rxo_discard,
   input  logic              rx_active,
   input  logic [CNT_W-1:0]  rx_bytes,
   input  logic              ev_link,
   input  logic              ev_ctr_roll,
   input  logic              ev_tx_halt,
   output logic              irq
);
   localparam int THR_FULL = ST_W + THR_SHIFT;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nic_irq_hub: ADDR_W must reach address 4");
   end
   if (CNT_W < THR_FULL) begin : g_bad_cnt
      $error("nic_irq_hub: CNT_W too narrow for the scaled threshold");
   end

   logic [ST_W-1:0]     status, mask, thr, ack;
   logic [N_EVT-1:0]    en;
   logic [N_STICKY-1:0] st_set, st_clr, st_q;
   logic                evt_any, erx_hit, rxo_any;
   logic [CNT_W-1:0]    thr_bytes;

   assign thr_bytes = CNT_W'({thr, {THR_SHIFT{1'b0}}});

   if (ERX_INCLUSIVE) begin : g_erx_ge
      assign erx_hit = rx_active && (rx_bytes >= thr_bytes);
   end else begin : g_erx_gt
      assign erx_hit = rx_active && (rx_bytes > thr_bytes);
   end

   assign rxo_any = rxo_nomem | rxo_toolong | rxo_discard;

   // sticky order: 0 transmit-empty, 1 receive-overrun, 2 early-receive
   assign st_set = {erx_hit, rxo_any, txq_empty};
   assign st_clr = {ack[ST_ERX], ack[ST_RXO], ack[ST_TXE]};

   nic_irq_sticky #(.N(N_STICKY)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set),
      .clr_i (st_clr),
      .q_o   (st_q)
   );

   nic_irq_evsum #(.N(N_EVT)) u_evsum (
      .ev_i  ({ev_tx_halt, ev_ctr_roll, ev_link}),
      .en_i  (en),
      .any_o (evt_any)
   );

   always_comb begin
      status           = '0;
      status[ST_RX]    = ~rxq_empty;
      status[ST_TX]    = ~txc_empty;
      status[ST_TXE]   = st_q[0];
      status[ST_ALLOC] = ~alloc_failed;
      status[ST_RXO]   = st_q[1];
      status[ST_EVT]   = evt_any;
      status[ST_ERX]   = st_q[2];
      status[ST_RSV]   = 1'b0;
   end

   nic_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .status_i (status),
      .mask_o   (mask),
      .en_o     (en),
      .thr_o    (thr),
      .ack_o    (ack),
      .rdata_o  (reg_rdata)
   );

   assign txc_pop = ack[ST_TX] & ~txc_empty;
   assign irq     = |(status & mask);

   // R2: never pop an empty completion queue
   p_pop_guard_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      txc_empty |-> !txc_pop);
   // R8: a cleared mask silences the line
   p_mask_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);
   // R5: any overrun cause shows in the status after the edge
   p_rxo_set_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      rxo_any |=> reg_rdata[ST_RXO] || (reg_addr != ADDR_W'(A_STAT)));
   // R5: without its acknowledge the overrun bit is never lost
   p_rxo_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[1] && !ack[ST_RXO]) |=> st_q[1]);
endmodule

// File: tb/nic_irq_hub_test.sv
`timescale 1ns/100ps
module nic_irq_hub_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       rxq_empty = 1'b1, txc_empty = 1'b1, txc_pop;
   logic       txq_empty = 1'b0, alloc_failed = 1'b1;
   logic       rxo_nomem = 1'b0, rxo_toolong = 1'b0, rxo_discard = 1'b0;
   logic       rx_active = 1'b0;
   logic [10:0] rx_bytes = 11'd0;
   logic       ev_link = 1'b0, ev_ctr_roll = 1'b0, ev_tx_halt = 1'b0;
   logic       irq;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int txq[$];
   bit m_txe = 0, m_rxo = 0, m_erx = 0;
   int m_mask = 0, m_en = 0, m_thr = 255;

   always #2.5 clk = ~clk;

   nic_irq_hub uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxq_empty(rxq_empty),
      .txc_empty(txc_empty), .txc_pop(txc_pop), .txq_empty(txq_empty),
      .alloc_failed(alloc_failed), .rxo_nomem(rxo_nomem),
      .rxo_toolong(rxo_toolong), .rxo_discard(rxo_discard),
      .rx_active(rx_active), .rx_bytes(rx_bytes), .ev_link(ev_link),
      .ev_ctr_roll(ev_ctr_roll), .ev_tx_halt(ev_tx_halt), .irq(irq)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int exp_status();
      int s;
      bit evt;
      evt = (ev_link && m_en[0]) || (ev_ctr_roll && m_en[1]) || (ev_tx_halt && m_en[2]);
      s = 0;
      s[0] = !rxq_empty;
      s[1] = (txq.size() != 0);
      s[2] = m_txe;
      s[3] = !alloc_failed;
      s[4] = m_rxo;
      s[5] = evt;
      s[6] = m_erx;
      return s;
   endfunction

   task automatic compare_all();
      int s, a;
      bit pop;
      s = exp_status();
      a = (reg_wr && reg_addr == 3'd2) ? int'(reg_wdata) : 0;
      pop = a[1] && (txq.size() != 0);
      chk("R8 irq", int'(irq), int'((s & m_mask) != 0));
      chk("R2 txc_pop", int'(txc_pop), int'(pop));
      case (reg_addr)
         3'd0: begin
            chk("R1 receive bit", int'(reg_rdata[0]), s[0]);
            chk("R2 transmit bit", int'(reg_rdata[1]), s[1]);
            chk("R4 tx-empty bit", int'(reg_rdata[2]), s[2]);
            chk("R3 alloc bit", int'(reg_rdata[3]), s[3]);
            chk("R5 overrun bit", int'(reg_rdata[4]), s[4]);
            chk("R7 summary bit", int'(reg_rdata[5]), s[5]);
            chk("R6 early-rx bit", int'(reg_rdata[6]), s[6]);
            chk("R1 reserved bit", int'(reg_rdata[7]), 0);
         end
         3'd1: chk("R11 mask read", int'(reg_rdata), m_mask);
         3'd3: chk("R11 enable read", int'(reg_rdata), m_en);
         3'd4: chk("R11 threshold read", int'(reg_rdata), m_thr);
         default: chk("R11 empty address read", int'(reg_rdata), 0);
      endcase
   endtask

   task automatic model_edge();
      int a;
      bit rxo_ev, erx_ev;
      a = (reg_wr && reg_addr == 3'd2) ? int'(reg_wdata) : 0;
      rxo_ev = rxo_nomem || rxo_toolong || rxo_discard;
      erx_ev = rx_active && (int'(rx_bytes) > m_thr * 8);
      m_txe = txq_empty || (m_txe && !a[2]);
      m_rxo = rxo_ev || (m_rxo && !a[4]);
      m_erx = erx_ev || (m_erx && !a[6]);
      if (a[1] && txq.size() != 0) void'(txq.pop_front());
      if (reg_wr && reg_addr == 3'd1) m_mask = int'(reg_wdata);
      if (reg_wr && reg_addr == 3'd3) m_en = int'(reg_wdata[2:0]);
      if (reg_wr && reg_addr == 3'd4) m_thr = int'(reg_wdata);
   endtask

   // one cycle: compare at negedge+1, then take the edge
   task automatic step();
      #1 compare_all();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      txc_empty = (txq.size() == 0);
      reg_wr = 1'b0;
      reg_addr = 3'd0;
   endtask

   task automatic wr(input int addr, input int data);
      reg_wr = 1'b1;
      reg_addr = 3'(addr);
      reg_wdata = 8'(data);
      step();
   endtask

   task automatic rd(input int addr);
      reg_addr = 3'(addr);
      step();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset values
      rd(0); rd(1); rd(2); rd(3); rd(4); rd(6);
      wr(1, 8'h7F);
      // R1
      rxq_empty = 1'b0; step(); step();
      rxq_empty = 1'b1; step();
      // R2: two completions, then an acknowledge on an empty queue
      txq.push_back(5); txq.push_back(9); txc_empty = 1'b0; step();
      wr(2, 8'h02); wr(2, 8'h02); wr(2, 8'h02); step();
      // R3
      alloc_failed = 1'b0; step(); alloc_failed = 1'b1; step();
      // R4: one-cycle empty, then hold, then acknowledge
      txq_empty = 1'b1; step(); txq_empty = 1'b0; step(); step();
      wr(2, 8'h04); step();
      // R9: set and acknowledge together
      txq_empty = 1'b1; wr(2, 8'h04); txq_empty = 1'b0;
      #1 chk("R9 set beats acknowledge", int'(reg_rdata[2]), 1);
      wr(2, 8'h04);
      // R5: each overrun cause, with acknowledges between
      rxo_nomem = 1'b1; step(); rxo_nomem = 1'b0; step();
      wr(2, 8'h04); wr(2, 8'h10);
      rxo_toolong = 1'b1; step(); rxo_toolong = 1'b0; step(); wr(2, 8'h10);
      rxo_discard = 1'b1; step(); rxo_discard = 1'b0; step(); wr(2, 8'h10);
      // R6: threshold 4 -> 32 bytes
      wr(4, 4); rd(4);
      rx_active = 1'b1; rx_bytes = 11'd32; step();
      rx_bytes = 11'd33; step();
      rx_active = 1'b0; step(); wr(2, 8'h40);
      rx_bytes = 11'd500; step(); step();
      // R7: each source under its enable
      ev_link = 1'b1; ev_ctr_roll = 1'b1; ev_tx_halt = 1'b1; step();
      wr(3, 1); step(); wr(3, 2); step(); wr(3, 4); step(); rd(3);
      ev_tx_halt = 1'b0; step(); wr(3, 7); step();
      // R10: acknowledges to live bits leave them alone
      rxq_empty = 1'b0; alloc_failed = 1'b0; step();
      wr(2, 8'hA9);
      #1 chk("R10 live bits unaffected", int'(reg_rdata), 8'h29);
      // R8: mask changes take effect at the next read
      wr(1, 8'h00); step(); wr(1, 8'h08); step();
      alloc_failed = 1'b1; step(); wr(1, 8'h7F);
      ev_link = 1'b0; ev_ctr_roll = 1'b0; rxq_empty = 1'b1;
      // mixed traffic
      lf = 32'h1d2c3b4a;
      for (int i = 0; i < 600; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         rxq_empty    = lf[0] | lf[1];
         txq_empty    = (lf[4:2] == 3'd0);
         alloc_failed = lf[5];
         rxo_nomem    = (lf[9:6] == 4'd3);
         rxo_toolong  = (lf[9:6] == 4'd5);
         rxo_discard  = (lf[9:6] == 4'd9);
         rx_active    = lf[10];
         rx_bytes     = 11'(lf[20:11]);
         ev_link      = lf[21];
         ev_ctr_roll  = lf[22];
         ev_tx_halt   = lf[23];
         if (lf[26:24] == 3'd1) begin
            txq.push_back(i);
            txc_empty = 1'b0;
         end
         reg_addr  = 3'(lf[29:27]);
         reg_wr    = lf[30] & lf[31];
         reg_wdata = 8'(lf[19:12]);
         if (reg_wr && reg_addr == 3'd4) reg_wdata = 8'(lf[15:12]);
         step();
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule